// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides the cycle in which a processor core stops and enters debug mode. Five kinds of request feed it: an external request line, a conditional software debug instruction whose condition evaluated true, a trace countdown, a breakpoint countdown, and address-match breakpoints on program and on data memory. The core supplies one pulse per pipeline event: an instruction was latched, an instruction completed, the completing instruction was killed, the core sits in its wait state, and which address comparators matched the completing instruction.

Each source has its own halt point in the instruction stream. The trace and breakpoint counters count down and stop at zero. When any source becomes due, the block raises one registered entry strobe and records every cause that was due in a cause vector. An external requester is answered with an acknowledge, and it must release its request before it can make another one. A request made while the core is waiting raises a wake output so that the core leaves the wait state.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, `dbg_enter_o`, `ext_ack_o`, `wake_o`, `cause_o` and both counters are zero.
- R2: A new assertion of `ext_req_i` sampled while `in_wait_i` is low is accepted. `dbg_enter_o` is then high for one cycle, in the cycle after the next executed instruction completes. An executed instruction is `instr_done_i` high with `instr_killed_i` low.
- R3: A new assertion of `ext_req_i` sampled while `in_wait_i` is high raises `wake_o` from the next cycle. Entry then follows in the cycle after the next `instr_latched_i`, and instruction completions alone do not trigger it.
- R4: `ext_ack_o` rises together with an entry that has cause bit 0 set. It stays high while `ext_req_i` is held and falls in the cycle after `ext_req_i` is sampled low. A request that stays held is not accepted a second time.
- R5: A completion with `sw_dbg_i` high arms a software request, and a killed instruction does not arm it. Entry follows in the cycle after the first `instr_latched_i` after that completion.
- R6: With `trace_en_i` high, each executed instruction decrements the trace counter. Entry follows in the cycle after the decrement from 1 to 0, with cause bit 2 set.
- R7: A killed instruction leaves the trace counter unchanged and causes no entry.
- R8: With `bkpt_en_i` high, each executed instruction with `pab_match_i` or `dab_match_i` decrements the breakpoint counter. When `pab_match_i` drives it from 1 to 0, entry follows in the next cycle with cause bit 3 set.
- R9: When a `dab_match_i` event alone drives the breakpoint counter from 1 to 0, entry follows in the cycle after the next executed instruction completes, with cause bit 4 set.
- R10: Sources that are due in the same cycle produce a single strobe, and `cause_o` holds all of them. The bits are: 0 external, 1 software, 2 trace, 3 program breakpoint, 4 data breakpoint.
- R11: `cnt_load_i` loads both counters from `trace_load_i` and `bkpt_load_i` and takes priority over a decrement. A counter at zero stays at zero and causes no entry.
- R12: `cause_o` holds its value until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | External debug request level |
| in_wait_i | input | 1 | Core is in the wait state |
| instr_latched_i | input | 1 | An instruction entered the instruction latch |
| instr_done_i | input | 1 | An instruction completed |
| instr_killed_i | input | 1 | The completing instruction was killed |
| sw_dbg_i | input | 1 | The completing instruction is a software debug request whose condition is true |
| trace_en_i | input | 1 | Trace mode enable |
| bkpt_en_i | input | 1 | Breakpoint counting enable |
| pab_match_i | input | 1 | Program address match on the completing instruction |
| dab_match_i | input | 1 | Data address match on the completing instruction |
| cnt_load_i | input | 1 | Load strobe for both counters |
| trace_load_i | input | CNT_W | Trace counter load value |
| bkpt_load_i | input | CNT_W | Breakpoint counter load value |
| dbg_enter_o | output | 1 | Debug entry strobe |
| cause_o | output | 5 | Causes of the latest entry |
| ext_ack_o | output | 1 | Acknowledge to the external requester |
| wake_o | output | 1 | Request to leave the wait state |
| trace_cnt_o | output | CNT_W | Trace counter value |
| bkpt_cnt_o | output | CNT_W | Breakpoint counter value |

## Verification
Every result of this block is registered once. The strobe, the cause vector and the acknowledge change in the cycle after the clock edge that samples the triggering completion or latch, and the counters change one edge after the event that loads or decrements them. `wake_o` follows one edge after the request is accepted. The bench applies each event at a falling edge and compares the outputs at the next falling edge, so every comparison falls in the cycle where the result is due. For each cycle of the trace, program-breakpoint and data-breakpoint sweeps, the expected strobe and count come from a running countdown kept in the bench.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
    localparam int CAUSE_N  = 5;
    localparam int CI_EXT   = 0;
    localparam int CI_SW    = 1;
    localparam int CI_TRACE = 2;
    localparam int CI_PBRK  = 3;
    localparam int CI_DBRK  = 4;

    typedef logic [CAUSE_N-1:0] cause_t;

    typedef struct packed {
        logic   sw_pend;
        logic   dab_pend;
        logic   enter;
        cause_t cause;
    } ctl_state_t;

    typedef struct packed {
        logic pend;
        logic wait_mode;
        logic held;
        logic ack;
    } ext_state_t;
endpackage

// File: rtl/dbg_sat_counter.sv
module dbg_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o,
    output logic         zero_hit_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_d, cnt_q;
    logic         hit_d;

    always_comb begin
        cnt_d = cnt_q;
        hit_d = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && cnt_q != ZERO) begin
            cnt_d = cnt_q - ONE;
            hit_d = (cnt_q == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign count_o    = cnt_q;
    assign zero_hit_o = hit_d;

    assert_stays_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == ZERO && !load_i) |=> (cnt_q == ZERO));
    assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
    assert_hit_reaches_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit_o |=> (cnt_q == ZERO));
endmodule

// File: rtl/dbg_ext_handshake.sv
module dbg_ext_handshake
    import dbg_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic in_wait_i,
    input  logic latched_i,
    input  logic exec_i,
    output logic due_o,
    output logic wake_o,
    output logic ack_o
);
    ext_state_t st_d, st_q;
    logic       due_d;

    always_comb begin
        st_d  = st_q;
        due_d = st_q.pend && (st_q.wait_mode ? latched_i : exec_i);
        if (due_d) begin
            st_d.pend = 1'b0;
            st_d.ack  = 1'b1;
        end else begin
            st_d.ack  = st_q.ack && req_i;
        end
        if (req_i && !st_q.held && !st_q.pend) begin
            st_d.pend      = 1'b1;
            st_d.held      = 1'b1;
            st_d.wait_mode = in_wait_i;
        end else if (!req_i && !st_q.pend) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign due_o  = due_d;
    assign wake_o = st_q.pend && st_q.wait_mode;
    assign ack_o  = st_q.ack;

    assert_ack_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o);
    assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !due_o) |=> !ack_o);
    assert_no_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !st_q.pend) |=> !st_q.pend);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_req_i,
    input  logic               in_wait_i,
    input  logic               instr_latched_i,
    input  logic               instr_done_i,
    input  logic               instr_killed_i,
    input  logic               sw_dbg_i,
    input  logic               trace_en_i,
    input  logic               bkpt_en_i,
    input  logic               pab_match_i,
    input  logic               dab_match_i,
    input  logic               cnt_load_i,
    input  logic [CNT_W-1:0]   trace_load_i,
    input  logic [CNT_W-1:0]   bkpt_load_i,
    output logic               dbg_enter_o,
    output logic [CAUSE_N-1:0] cause_o,
    output logic               ext_ack_o,
    output logic               wake_o,
    output logic [CNT_W-1:0]   trace_cnt_o,
    output logic [CNT_W-1:0]   bkpt_cnt_o
);
    ctl_state_t st_d, st_q;
    cause_t     due;
    logic       exec, trace_dec, brk_evt, trace_hit, brk_hit, ext_due;

    assign exec      = instr_done_i && !instr_killed_i;
    assign trace_dec = trace_en_i && exec;
    assign brk_evt   = bkpt_en_i && exec && (pab_match_i || dab_match_i);

    dbg_sat_counter #(.W(CNT_W)) u_trace_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load_i),
        .load_val_i (trace_load_i),
        .dec_i      (trace_dec),
        .count_o    (trace_cnt_o),
        .zero_hit_o (trace_hit)
    );

    dbg_sat_counter #(.W(CNT_W)) u_brk_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load_i),
        .load_val_i (bkpt_load_i),
        .dec_i      (brk_evt),
        .count_o    (bkpt_cnt_o),
        .zero_hit_o (brk_hit)
    );

    dbg_ext_handshake u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (ext_req_i),
        .in_wait_i (in_wait_i),
        .latched_i (instr_latched_i),
        .exec_i    (exec),
        .due_o     (ext_due),
        .wake_o    (wake_o),
        .ack_o     (ext_ack_o)
    );

    always_comb begin
        st_d            = st_q;
        due             = '0;
        due[CI_EXT]     = ext_due;
        due[CI_SW]      = st_q.sw_pend && instr_latched_i;
        due[CI_TRACE]   = trace_hit;
        due[CI_PBRK]    = brk_hit && pab_match_i;
        due[CI_DBRK]    = st_q.dab_pend && exec;
        st_d.sw_pend    = (st_q.sw_pend && !instr_latched_i) || (exec && sw_dbg_i);
        st_d.dab_pend   = (st_q.dab_pend && !exec) ||
                          (brk_hit && dab_match_i && !pab_match_i);
        st_d.enter      = |due;
        st_d.cause      = (|due) ? due : st_q.cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_enter_o = st_q.enter;
    assign cause_o     = st_q.cause;

    assert_enter_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter_o |-> (cause_o != '0));
    assert_ack_with_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ack_o) |-> (dbg_enter_o && cause_o[CI_EXT]));
    assert_killed_no_trace_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done_i && instr_killed_i && !cnt_load_i) |=> $stable(trace_cnt_o));
    assert_cause_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o != $past(cause_o)) |-> dbg_enter_o);
endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 0, in_wait = 0, latched = 0, done = 0, killed = 0, sw = 0;
    logic trace_en = 0, bkpt_en = 0, pab = 0, dab = 0, load = 0;
    logic [CNT_W-1:0] trace_ld = '0, bkpt_ld = '0;
    logic dbg_enter, ext_ack, wake;
    logic [4:0] cause;
    logic [CNT_W-1:0] trace_cnt, bkpt_cnt;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    dbg_entry_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req), .in_wait_i(in_wait),
        .instr_latched_i(latched), .instr_done_i(done), .instr_killed_i(killed),
        .sw_dbg_i(sw), .trace_en_i(trace_en), .bkpt_en_i(bkpt_en),
        .pab_match_i(pab), .dab_match_i(dab), .cnt_load_i(load),
        .trace_load_i(trace_ld), .bkpt_load_i(bkpt_ld),
        .dbg_enter_o(dbg_enter), .cause_o(cause), .ext_ack_o(ext_ack),
        .wake_o(wake), .trace_cnt_o(trace_cnt), .bkpt_cnt_o(bkpt_cnt)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        latched = 0; done = 0; killed = 0; sw = 0; pab = 0; dab = 0; load = 0;
    endtask

    task automatic load_cnt(input int t, input int b);
        load = 1; trace_ld = CNT_W'(t); bkpt_ld = CNT_W'(b);
        tick();
        chk(trace_cnt, t, "R11 trace load");
        chk(bkpt_cnt, b, "R11 bkpt load");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(dbg_enter, 0, "R1 enter"); chk(ext_ack, 0, "R1 ack");
        chk(wake, 0, "R1 wake"); chk(cause, 0, "R1 cause");
        chk(trace_cnt, 0, "R1 trace"); chk(bkpt_cnt, 0, "R1 bkpt");

        // R6 / R7 trace sweep with every third instruction killed
        trace_en = 1;
        for (int n = 1; n <= 6; n++) begin
            int tc;
            load_cnt(n, 0);
            tc = n;
            for (int i = 0; i < 2*n + 4; i++) begin
                logic ex, hit;
                done = 1; killed = (i % 3 == 2);
                ex = !killed;
                hit = ex && (tc == 1);
                if (ex && tc > 0) tc--;
                tick();
                chk(dbg_enter, hit, "R6 trace entry");
                chk(trace_cnt, tc, "R7 trace count");
                if (hit) chk(cause, 5'b00100, "R6 trace cause");
            end
        end
        trace_en = 0;

        // R8 program breakpoint sweep
        bkpt_en = 1;
        for (int n = 1; n <= 4; n++) begin
            int bc;
            load_cnt(0, n);
            bc = n;
            for (int i = 0; i < 2*n + 3; i++) begin
                logic hit;
                done = 1; pab = (i % 2 == 0);
                hit = pab && (bc == 1);
                if (pab && bc > 0) bc--;
                tick();
                chk(dbg_enter, hit, "R8 pbrk entry");
                chk(bkpt_cnt, bc, "R8 bkpt count");
                if (hit) chk(cause, 5'b01000, "R8 pbrk cause");
            end
        end

        // R9 data breakpoint sweep, killed slot after each match
        for (int n = 1; n <= 3; n++) begin
            int bc;
            logic pend;
            load_cnt(0, n);
            bc = n; pend = 0;
            for (int i = 0; i < 4*n + 4; i++) begin
                logic ex, hit, expd;
                done = 1; killed = (i % 4 == 1); dab = (i % 4 == 0);
                ex = !killed;
                hit = ex && dab && (bc == 1);
                expd = pend && ex;
                pend = (pend && !ex) || hit;
                if (ex && dab && bc > 0) bc--;
                tick();
                chk(dbg_enter, expd, "R9 dbrk entry");
                if (expd) chk(cause, 5'b10000, "R9 dbrk cause");
            end
        end
        bkpt_en = 0;

        // R5 software request
        done = 1; sw = 1; killed = 1; tick();
        latched = 1; tick();
        chk(dbg_enter, 0, "R5 killed sw does not arm");
        done = 1; sw = 1; tick();
        chk(dbg_enter, 0, "R5 not yet");
        done = 1; tick();
        chk(dbg_enter, 0, "R5 waits for latch");
        latched = 1; tick();
        chk(dbg_enter, 1, "R5 sw entry");
        chk(cause, 5'b00010, "R5 sw cause");

        // R2 / R4 external request outside wait
        ext_req = 1; tick();
        chk(dbg_enter, 0, "R2 accept cycle");
        tick();
        chk(dbg_enter, 0, "R2 waits for completion");
        done = 1; tick();
        chk(dbg_enter, 1, "R2 ext entry");
        chk(cause, 5'b00001, "R2 ext cause");
        chk(ext_ack, 1, "R4 ack rises");
        for (int i = 0; i < 4; i++) begin
            done = 1; latched = 1; tick();
            chk(dbg_enter, 0, "R4 held request no re-entry");
            chk(ext_ack, 1, "R4 ack held");
        end
        ext_req = 0; tick();
        chk(ext_ack, 0, "R4 ack released");

        // R3 external request during wait
        in_wait = 1; ext_req = 1; tick();
        chk(wake, 1, "R3 wake");
        done = 1; tick();
        chk(dbg_enter, 0, "R3 completion alone");
        in_wait = 0; latched = 1; tick();
        chk(dbg_enter, 1, "R3 wait entry");
        chk(wake, 0, "R3 wake cleared");
        ext_req = 0; tick();
        chk(ext_ack, 0, "R4 ack drop after wait entry");
        // R12 cause held
        tick();
        chk(cause, 5'b00001, "R12 cause hold");
        chk(dbg_enter, 0, "R12 no strobe");

        // R10 simultaneous causes
        trace_en = 1; bkpt_en = 1;
        load_cnt(1, 1);
        done = 1; pab = 1; tick();
        chk(dbg_enter, 1, "R10 one strobe");
        chk(cause, 5'b01100, "R10 merged cause");
        tick();
        chk(dbg_enter, 0, "R10 single cycle");

        // R11 load priority and saturation
        load = 1; trace_ld = 5; bkpt_ld = 3; done = 1; pab = 1; tick();
        chk(trace_cnt, 5, "R11 load over decrement");
        chk(bkpt_cnt, 3, "R11 load over decrement bkpt");
        load_cnt(0, 0);
        done = 1; pab = 1; tick();
        chk(trace_cnt, 0, "R11 saturate trace");
        chk(bkpt_cnt, 0, "R11 saturate bkpt");
        chk(dbg_enter, 0, "R11 no entry at zero");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule